// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the slave end of a byte-wide serial EEPROM with a 512-byte storage array held inside it. A host talks to it over a four-wire serial link in mode 0. A chip-select line frames each transaction. Data is sampled on the rising edge of the serial clock and driven on the falling edge. A pause input and a write-protect input are also provided. The first byte of each transaction is a command. The block carries out array reads, page writes, write-enable latch set and clear, and status register reads and writes.

All pins are sampled in the block's own clock domain, which must run at several times the serial clock rate. Edges of the serial clock and chip select are detected by comparing each sample with the one before it. The serial output is given as a data bit plus an enable; the pad turns the output to high impedance whenever the enable is low. A programming counter stands in for the slow internal write. While it runs, the busy bit of the status register is set.

Top module: `eep_spi_slave`

## Requirements
- R1: After a synchronous reset, so_oe_o is low, the status byte reads 0x00 and every array byte reads 0x00.
- R2: While cs_n_i is high, so_oe_o is low and serial clock activity and si_i are ignored. A falling edge of cs_n_i restarts the protocol from the command byte, even after a transaction that was cut short.
- R3: Bytes are shifted most significant bit first. si_i is sampled on the rising edge of sck_i, and so_o changes only on the falling edge of sck_i.
- R4: Command encodings: 0x06 sets the write-enable latch, 0x04 clears it, 0x05 reads status, and 0x01 writes status. Read is 0000_A011 and write is 0000_A010, where bit 3 carries address bit 8 and the next byte carries address bits 7..0.
- R5: A read returns the byte at the address, then the following bytes for as long as clocks continue. The address wraps from 0x1FF to 0x000.
- R6: A write needs the latch set before the command. Data bytes fill an 8-byte page, and the low 3 address bits wrap inside that page. Programming starts only when cs_n_i rises after a whole number of data bytes. A rise in the middle of a byte discards the write.
- R7: Status bit 0 (busy) is 1 for PROG_CYCLES clocks after programming starts. Status bit 1 (latch) is cleared when programming ends. While busy, every command other than status read is ignored and so_oe_o stays low.
- R8: A status write with the latch set stores data bits 3:2 into status bits 3:2 and runs a programming cycle. Without the latch set it has no effect. Status bits 7:4 always read 0.
- R9: An unrecognised command byte, including a read or write pattern with a nonzero upper nibble, makes the block ignore si_i and keep so_oe_o low until the next falling edge of cs_n_i.
- R10: Pause starts when hold_n_i is low while sck_i is low, and ends when hold_n_i is high while sck_i is low. While paused, so_oe_o is low, and serial clock edges and si_i bits change neither the bit position nor the shifted data. On release, so_o resumes with the same bit.
- R11: While wp_n_i is low no write or status write is accepted. If wp_n_i falls at any point while such a command is being shifted in, that command is cancelled.
- R12: A fall of wp_n_i after programming has started does not affect that programming.
- R13: A status read keeps returning the current status byte for as many bytes as the host clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, several times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host, already synchronised to clk |
| cs_n_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data from the host |
| hold_n_i | input | 1 | Active-low pause request |
| wp_n_i | input | 1 | Active-low write protect |
| so_o | output | 1 | Serial data to the host |
| so_oe_o | output | 1 | Output enable for so_o; low means the pad is high impedance |

## Verification
Most internal faults reach the serial output within one serial bit time. A wrong bit counter, a wrong shift register or a wrong address pointer gives a bad so_o bit on the next falling clock edge of a read. A wrong state, or a pause that is not respected, raises so_oe_o when it should stay low one clock after the edge that caused it. Faults in the write path, the write-enable latch and write protect only show up later, either in a status read or when the affected page is read back after the programming delay. The bench therefore follows every command that should change something with a status read and an array read.

// File: rtl/eep_pkg.sv
// Package: shared constants and state type for the serial EEPROM slave.
// Assumes a 512-byte array (9-bit address, bit 8 carried in the command).
package eep_pkg;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD   = 8'h05;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;
    localparam logic [2:0] OP_ARR_RD    = 3'b011;
    localparam logic [2:0] OP_ARR_WR    = 3'b010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RDDAT,
        ST_WRDAT,
        ST_STRD,
        ST_STWR,
        ST_DONE,
        ST_DEAD
    } eep_state_e;

endpackage

// File: rtl/eep_pin_sampler.sv
// Module: edge detection on the serial clock and chip select, plus pause
// tracking. Assumes all inputs are already synchronous to clk.
module eep_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic hold_n_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic cs_fall_o,
    output logic cs_rise_o,
    output logic hold_o
);

    logic sck_q;
    logic cs_q;
    logic hold_q;

    // Keep last samples of the serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_i;
            cs_q  <= cs_n_i;
        end
    end

    // Pause state: enters and leaves only while the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (cs_n_i) begin
            hold_q <= 1'b0;
        end else if (!sck_i) begin
            hold_q <= !hold_n_i;
        end
    end

    assign sck_rise_o = sck_i & ~sck_q;
    assign sck_fall_o = ~sck_i & sck_q;
    assign cs_fall_o  = ~cs_n_i & cs_q;
    assign cs_rise_o  = cs_n_i & ~cs_q;
    assign hold_o     = hold_q;

endmodule

// File: rtl/eep_prog_timer.sv
// Module: models the internal programming delay. A start pulse holds busy
// high for PROG_CYCLES clocks, then a one-clock done pulse follows.
// Assumes PROG_CYCLES >= 2; a start while busy is ignored.
module eep_prog_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(PROG_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Count down the programming window and flag its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            cnt    <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !busy_o) begin
                busy_o <= 1'b1;
                cnt    <= CNT_W'(PROG_CYCLES - 1);
            end else if (busy_o) begin
                if (cnt == '0) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/eep_array.sv
// Module: the byte storage. One combinational read port, plus a page write
// port that stores any subset of the lanes of one page in a single clock.
// Assumes PAGE_BYTES is a power of two; reset clears the contents.
module eep_array
    import eep_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - PAGE_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  rd_addr_i,
    output logic [DATA_W-1:0]                  rd_data_o,
    input  logic                               wr_en_i,
    input  logic [PG_W-1:0]                    wr_page_i,
    input  logic [PAGE_BYTES-1:0]              wr_mask_i,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0]  wr_data_i
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the masked lanes of one page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en_i) begin
            for (int l = 0; l < PAGE_BYTES; l++) begin
                if (wr_mask_i[l]) begin
                    mem[{wr_page_i, PAGE_W'(l)}] <= wr_data_i[l];
                end
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/eep_cmd_fsm.sv
// Module: serial protocol engine. Shifts bytes in and out, decodes commands,
// collects page data, holds the write-enable latch and status field, and
// requests programming. Assumes edge strobes come from eep_pin_sampler.
module eep_cmd_fsm
    import eep_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - PAGE_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cs_n_i,
    input  logic                               si_i,
    input  logic                               wp_n_i,
    input  logic                               sck_rise_i,
    input  logic                               sck_fall_i,
    input  logic                               cs_fall_i,
    input  logic                               cs_rise_i,
    input  logic                               hold_i,
    input  logic                               busy_i,
    input  logic                               prog_done_i,
    output logic [ADDR_W-1:0]                  rd_addr_o,
    input  logic [DATA_W-1:0]                  rd_data_i,
    output logic                               wr_en_o,
    output logic [PG_W-1:0]                    wr_page_o,
    output logic [PAGE_BYTES-1:0]              wr_mask_o,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]  wr_data_o,
    output logic                               prog_start_o,
    output logic                               so_o,
    output logic                               so_oe_o
);

    eep_state_e st;
    logic [2:0]                        bit_cnt;
    logic [DATA_W-1:0]                 shreg;
    logic [DATA_W-1:0]                 tx;
    logic                              a8;
    logic                              is_read;
    logic                              armed;
    logic                              wel;
    logic [1:0]                        bp;
    logic [1:0]                        sr_new;
    logic                              sr_pend;
    logic [ADDR_W-1:0]                 rd_ptr;
    logic [PAGE_W-1:0]                 wr_off;
    logic [PG_W-1:0]                   pg;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] pg_buf;
    logic [PAGE_BYTES-1:0]             pg_mask;
    logic                              so_q;
    logic                              live;

    logic              rise_e;
    logic              fall_e;
    logic              byte_done;
    logic [7:0]        byte_in;
    logic [ADDR_W-1:0] full_addr;
    logic [7:0]        status;
    logic              op_is_rd;
    logic              op_is_wr;
    logic              out_state;

    // Effective edges, input byte, status byte and command class.
    always_comb begin
        rise_e    = sck_rise_i & ~hold_i & ~cs_n_i;
        fall_e    = sck_fall_i & ~hold_i & ~cs_n_i;
        byte_in   = {shreg[6:0], si_i};
        byte_done = rise_e && (bit_cnt == 3'd7)
                    && (st != ST_IDLE) && (st != ST_DEAD);
        full_addr = {a8, byte_in};
        status    = {4'b0000, bp, wel, busy_i};
        op_is_rd  = (byte_in[7:4] == 4'h0) && (byte_in[2:0] == OP_ARR_RD);
        op_is_wr  = (byte_in[7:4] == 4'h0) && (byte_in[2:0] == OP_ARR_WR);
        out_state = (st == ST_RDDAT) || (st == ST_STRD);
    end

    // Programming request at a chip-select rise on a byte boundary.
    always_comb begin
        prog_start_o = cs_rise_i && armed && !busy_i && (bit_cnt == 3'd0)
                       && (((st == ST_WRDAT) && (pg_mask != '0))
                           || ((st == ST_DONE) && sr_pend));
        wr_en_o   = prog_start_o && (st == ST_WRDAT);
        wr_page_o = pg;
        wr_mask_o = pg_mask;
        wr_data_o = pg_buf;
        rd_addr_o = (st == ST_ADDR) ? full_addr : rd_ptr;
        so_o      = so_q;
        so_oe_o   = live && !hold_i && out_state;
    end

    // Protocol sequencing, shifting and command side effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            a8      <= 1'b0;
            is_read <= 1'b0;
            armed   <= 1'b0;
            wel     <= 1'b0;
            bp      <= '0;
            sr_new  <= '0;
            sr_pend <= 1'b0;
            rd_ptr  <= '0;
            wr_off  <= '0;
            pg      <= '0;
            pg_buf  <= '0;
            pg_mask <= '0;
            so_q    <= 1'b0;
            live    <= 1'b0;
        end else begin
            if (prog_done_i) begin
                wel <= 1'b0;
            end
            if (!wp_n_i) begin
                armed <= 1'b0;
            end
            if (cs_fall_i) begin
                st      <= ST_CMD;
                bit_cnt <= '0;
                live    <= 1'b0;
                armed   <= 1'b0;
                sr_pend <= 1'b0;
                pg_mask <= '0;
            end else if (cs_n_i) begin
                st   <= ST_IDLE;
                live <= 1'b0;
                if (prog_start_o && (st == ST_DONE)) begin
                    bp <= sr_new;
                end
            end else if ((st != ST_IDLE) && (st != ST_DEAD)) begin
                if (rise_e) begin
                    shreg   <= byte_in;
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (byte_done) begin
                    case (st)
                        ST_CMD: begin
                            if (busy_i && (byte_in != OP_STAT_RD)) begin
                                st <= ST_DEAD;
                            end else if (byte_in == OP_LATCH_SET) begin
                                wel <= 1'b1;
                                st  <= ST_DONE;
                            end else if (byte_in == OP_LATCH_CLR) begin
                                wel <= 1'b0;
                                st  <= ST_DONE;
                            end else if (byte_in == OP_STAT_RD) begin
                                tx <= status;
                                st <= ST_STRD;
                            end else if (byte_in == OP_STAT_WR) begin
                                armed <= wel && wp_n_i;
                                st    <= ST_STWR;
                            end else if (op_is_rd || op_is_wr) begin
                                a8      <= byte_in[3];
                                is_read <= op_is_rd;
                                armed   <= op_is_wr && wel && wp_n_i;
                                st      <= ST_ADDR;
                            end else begin
                                st <= ST_DEAD;
                            end
                        end
                        ST_ADDR: begin
                            if (is_read) begin
                                tx     <= rd_data_i;
                                rd_ptr <= full_addr + 1'b1;
                                st     <= ST_RDDAT;
                            end else begin
                                pg     <= full_addr[ADDR_W-1:PAGE_W];
                                wr_off <= full_addr[PAGE_W-1:0];
                                st     <= ST_WRDAT;
                            end
                        end
                        ST_RDDAT: begin
                            tx     <= rd_data_i;
                            rd_ptr <= rd_ptr + 1'b1;
                        end
                        ST_WRDAT: begin
                            pg_buf[wr_off]  <= byte_in;
                            pg_mask[wr_off] <= 1'b1;
                            wr_off          <= wr_off + 1'b1;
                        end
                        ST_STRD: begin
                            tx <= status;
                        end
                        ST_STWR: begin
                            sr_new  <= byte_in[3:2];
                            sr_pend <= 1'b1;
                            st      <= ST_DONE;
                        end
                        default: begin
                        end
                    endcase
                end
                if (fall_e && out_state) begin
                    so_q <= tx[~bit_cnt];
                    live <= 1'b1;
                end
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i)) |-> !so_oe_o);                          // R2
    AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_e |=> $stable(so_q));                                       // R3
    AST_PROG_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |-> wel);                                            // R6
    AST_BUSY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_CMD) && byte_done && busy_i)
        |=> ((st == ST_DEAD) || (st == ST_STRD)));                        // R7
    AST_DEAD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_DEAD) && !cs_fall_i)
        |=> ((st == ST_DEAD) || (st == ST_IDLE)));                        // R9
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !cs_n_i && !cs_fall_i)
        |=> ($stable(bit_cnt) && $stable(shreg)));                        // R10
    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |-> $past(wp_n_i));                                  // R11

endmodule

// File: rtl/eep_spi_slave.sv
// Module: top of the serial EEPROM slave. Connects pin sampling, the
// protocol engine, the programming timer and the storage array.
// Assumes pins are synchronous to clk and clk runs well above sck.
module eep_spi_slave
    import eep_pkg::*;
#(
    parameter int PAGE_BYTES  = 8,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic si_i,
    input  logic hold_n_i,
    input  logic wp_n_i,
    output logic so_o,
    output logic so_oe_o
);

    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int PG_W   = ADDR_W - PAGE_W;

    logic sck_rise, sck_fall, cs_fall, cs_rise, hold;
    logic busy, prog_done, prog_start;
    logic [ADDR_W-1:0]                 rd_addr;
    logic [DATA_W-1:0]                 rd_data;
    logic                              wr_en;
    logic [PG_W-1:0]                   wr_page;
    logic [PAGE_BYTES-1:0]             wr_mask;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] wr_data;

    eep_pin_sampler u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .cs_n_i     (cs_n_i),
        .hold_n_i   (hold_n_i),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .cs_fall_o  (cs_fall),
        .cs_rise_o  (cs_rise),
        .hold_o     (hold)
    );

    eep_cmd_fsm #(.PAGE_BYTES(PAGE_BYTES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_i       (cs_n_i),
        .si_i         (si_i),
        .wp_n_i       (wp_n_i),
        .sck_rise_i   (sck_rise),
        .sck_fall_i   (sck_fall),
        .cs_fall_i    (cs_fall),
        .cs_rise_i    (cs_rise),
        .hold_i       (hold),
        .busy_i       (busy),
        .prog_done_i  (prog_done),
        .rd_addr_o    (rd_addr),
        .rd_data_i    (rd_data),
        .wr_en_o      (wr_en),
        .wr_page_o    (wr_page),
        .wr_mask_o    (wr_mask),
        .wr_data_o    (wr_data),
        .prog_start_o (prog_start),
        .so_o         (so_o),
        .so_oe_o      (so_oe_o)
    );

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy),
        .done_o  (prog_done)
    );

    eep_array #(.PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en),
        .wr_page_i (wr_page),
        .wr_mask_i (wr_mask),
        .wr_data_i (wr_data)
    );

endmodule

// File: tb/tb_eep_spi_slave.sv
// Bench: drives the serial pins from tasks and keeps a behavioural model
// (byte array, latch, status field, queue of expected output bits). The
// output pair is compared with the model on every clock.
module tb_eep_spi_slave;

    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic hold_n = 1'b1;
    logic wp_n = 1'b1;
    logic so, so_oe;

    always #4 clk = ~clk;

    eep_spi_slave #(.PAGE_BYTES(8), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .hold_n_i(hold_n), .wp_n_i(wp_n), .so_o(so), .so_oe_o(so_oe)
    );

    int vectors = 0;
    int errs = 0;
    bit finished = 0;
    string cur_req = "R1";
    logic exp_oe = 1'b0;
    logic exp_bit = 1'b0;
    bit rd_active = 0;
    bit in_hold = 0;
    logic bitq[$];
    logic [7:0] wq[$];
    logic [7:0] mem_m [512];
    logic wel_m = 1'b0;
    logic [1:0] bp_m = 2'b00;

    function automatic logic [7:0] stat(input logic busy, input logic wel);
        return {4'b0000, bp_m, wel, busy};
    endfunction

    task automatic tick();
        @(negedge clk);
        vectors++;
        if (so_oe !== exp_oe || (exp_oe && so !== exp_bit)) begin
            errs++;
            $display("FAIL %s: so_oe/so = %b/%b expected %b/%b (vector %0d)",
                     cur_req, so_oe, so, exp_oe, exp_bit, vectors);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bitq.push_back(b[i]);
    endtask

    // One serial clock half period; a falling edge in a read pops a bit.
    task automatic half(input logic level);
        sck = level;
        if (!level && rd_active && !in_hold && bitq.size() > 0) begin
            exp_bit = bitq.pop_front();
            exp_oe  = 1'b1;
        end
        ticks(4);
    endtask

    task automatic hold_pause();
        hold_n = 1'b0; exp_oe = 1'b0; in_hold = 1; ticks(4);
        si = ~si;
        half(1'b1); half(1'b0); half(1'b1); half(1'b0);
        hold_n = 1'b1; exp_oe = rd_active; in_hold = 0; ticks(4);
    endtask

    task automatic xfer_bits(input logic [7:0] b, input int nbits,
                             input bit start_rd, input int hold_after);
        for (int i = 7; i > 7 - nbits; i--) begin
            si = b[i];
            half(1'b1);
            if (start_rd && i == 0) rd_active = 1;
            half(1'b0);
            if (hold_after == 7 - i) hold_pause();
        end
    endtask

    task automatic xfer(input logic [7:0] b, input bit start_rd);
        xfer_bits(b, 8, start_rd, -1);
    endtask

    task automatic cs_low();
        cs_n = 1'b0; ticks(4);
    endtask

    task automatic cs_high();
        cs_n = 1'b1; rd_active = 0; exp_oe = 1'b0; bitq.delete(); ticks(4);
    endtask

    task automatic rdsr(input logic [7:0] expv, input int nbytes);
        for (int k = 0; k <= nbytes; k++) push_byte(expv);
        cs_low();
        xfer(8'h05, 1);
        for (int k = 0; k < nbytes; k++) xfer(8'h00, 0);
        cs_high();
    endtask

    task automatic read_mem(input logic [8:0] a, input int n, input int hold_at);
        for (int k = 0; k <= n; k++) push_byte(mem_m[9'(a + 9'(k))]);
        cs_low();
        xfer({4'h0, a[8], 3'b011}, 0);
        xfer(a[7:0], 1);
        for (int k = 0; k < n; k++) xfer_bits(8'h00, 8, 0, (k == 0) ? hold_at : -1);
        cs_high();
    endtask

    // Shift a page write from wq; the model is updated only when commit is set.
    task automatic write_mem(input logic [8:0] a, input bit commit);
        cs_low();
        xfer({4'h0, a[8], 3'b010}, 0);
        xfer(a[7:0], 0);
        for (int k = 0; k < wq.size(); k++) begin
            xfer(wq[k], 0);
            if (commit) mem_m[{a[8:3], 3'(a[2:0] + 3'(k))}] = wq[k];
        end
        cs_high();
        wq.delete();
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_low(); xfer(op, 0); cs_high();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
        // R1: reset state
        cur_req = "R1";
        ticks(4);
        rst_n = 1'b1;
        ticks(4);
        rdsr(stat(0, 0), 1);
        read_mem(9'h000, 2, -1);

        // R4: latch set and clear
        cur_req = "R4";
        cmd1(8'h06); wel_m = 1'b1;
        rdsr(stat(0, 1), 1);
        cmd1(8'h04); wel_m = 1'b0;
        rdsr(stat(0, 0), 1);

        // R6: write without the latch is refused
        cur_req = "R6";
        wq.push_back(8'hAA);
        write_mem(9'h010, 0);
        rdsr(stat(0, 0), 1);
        read_mem(9'h010, 1, -1);

        // R6: low-page write, R3 MSB-first read back
        cmd1(8'h06);
        wq.push_back(8'h5A); wq.push_back(8'hA5); wq.push_back(8'hC3);
        write_mem(9'h000, 1);
        ticks(PROG + 20);
        cur_req = "R3";
        read_mem(9'h000, 3, -1);

        // R6/R7: top-page write wrapping in the page, busy status, busy gating
        cur_req = "R7";
        cmd1(8'h06);
        wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
        wq.push_back(8'h44); wq.push_back(8'h55);
        write_mem(9'h1FD, 1);
        rdsr(stat(1, 1), 1);
        cs_low(); xfer(8'h0B, 0); xfer(8'hF8, 0); xfer(8'h00, 0); cs_high();
        ticks(PROG + 20); wel_m = 1'b0;
        rdsr(stat(0, 0), 1);
        cur_req = "R6";
        read_mem(9'h1F8, 8, -1);
        // R5: auto-increment across the top of the array
        cur_req = "R5";
        read_mem(9'h1FE, 4, -1);

        // R6: chip-select rise mid-byte discards the write
        cur_req = "R6";
        cmd1(8'h06); wel_m = 1'b1;
        cs_low(); xfer(8'h02, 0); xfer(8'h20, 0); xfer(8'h77, 0);
        xfer_bits(8'hF0, 4, 0, -1); si = 1'b0; cs_high();
        rdsr(stat(0, 1), 1);
        read_mem(9'h020, 1, -1);

        // R11: write protect low refuses, a fall mid-shift cancels
        cur_req = "R11";
        wp_n = 1'b0;
        wq.push_back(8'h99);
        write_mem(9'h030, 0);
        wp_n = 1'b1;
        rdsr(stat(0, 1), 1);
        read_mem(9'h030, 1, -1);
        cs_low(); xfer(8'h02, 0); xfer(8'h30, 0); xfer(8'h99, 0);
        wp_n = 1'b0; ticks(2); wp_n = 1'b1; ticks(2);
        xfer(8'h88, 0); cs_high();
        rdsr(stat(0, 1), 1);
        read_mem(9'h030, 2, -1);

        // R12: write protect falling after programming starts
        cur_req = "R12";
        wq.push_back(8'h99);
        write_mem(9'h030, 1);
        wp_n = 1'b0;
        rdsr(stat(1, 1), 1);
        ticks(PROG + 20); wel_m = 1'b0;
        wp_n = 1'b1;
        rdsr(stat(0, 0), 1);
        read_mem(9'h030, 1, -1);

        // R8: status write with and without the latch
        cur_req = "R8";
        cs_low(); xfer(8'h01, 0); xfer(8'h08, 0); cs_high();
        rdsr(stat(0, 0), 1);
        cmd1(8'h06); wel_m = 1'b1;
        cs_low(); xfer(8'h01, 0); xfer(8'hF4, 0); cs_high();
        bp_m = 2'b01;
        rdsr(stat(1, 1), 1);
        ticks(PROG + 20); wel_m = 1'b0;
        rdsr(stat(0, 0), 1);

        // R9: unknown commands silence the block until the next select
        cur_req = "R9";
        cs_low(); xfer(8'hFF, 0); xfer(8'h05, 0); xfer(8'h06, 0); cs_high();
        rdsr(stat(0, 0), 1);
        cs_low(); xfer(8'h13, 0); xfer(8'h00, 0); xfer(8'h00, 0); cs_high();
        rdsr(stat(0, 0), 1);

        // R10: pause mid-byte during a read
        cur_req = "R10";
        read_mem(9'h1F8, 2, 3);

        // R13: status repeats
        cur_req = "R13";
        rdsr(stat(0, 0), 3);

        // R2: activity with select high is ignored; a new select restarts
        cur_req = "R2";
        si = 1'b1; half(1'b1); half(1'b0); half(1'b1); half(1'b0);
        cs_low(); xfer_bits(8'h03, 4, 0, -1); cs_high();
        read_mem(9'h001, 2, -1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule